// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two N-bit operands over several clock cycles. It uses one N-bit adder and a 2N-bit accumulator that rotates right by one place each cycle, with a carry bit as the extra stage. A one-cycle `start` pulse captures both operands and a signed/unsigned select. Some cycles later the block returns a 2N-bit product as separate high and low halves, a one-cycle `done` pulse, and a flag that says whether the result needs more than the low half.

Signed products are formed from operand magnitudes. The unsigned core runs on the magnitudes. If the operand signs differ, the 2N-bit result is negated in a final fix cycle.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. The LOAD transition goes from `ST_IDLE` to `ST_ITER` on an accepted start. It clears the accumulator, loads the iteration counter with N and captures the magnitudes.
- `ST_ITER` runs one shift/add/rotate step per cycle. The STEP transition loops from `ST_ITER` to `ST_ITER` while the counter is above one. The LAST transition goes from `ST_ITER` to `ST_FIX` on the final step.
- `ST_FIX` does the sign correction and computes the flag. The PUBLISH transition goes from `ST_FIX` to `ST_IDLE`. It registers the product and the flag and raises `done`.

Top module: `shift_add_mul`

## Requirements
- R1: After reset `prod_hi`, `prod_lo`, `ovf`, `done` and `busy` are all 0.
- R2: With `sgn_mode`=0, {`prod_hi`,`prod_lo`} equals the unsigned product of `opa` and `opb` as captured at the accepted start.
- R3: With `sgn_mode`=1, {`prod_hi`,`prod_lo`} equals the 2N-bit two's-complement product of `opa` and `opb`, each read as two's complement.
- R4: In unsigned mode, `ovf` is 1 exactly when `prod_hi` is nonzero.
- R5: In signed mode, `ovf` is 0 exactly when every bit of `prod_hi` equals bit N-1 of `prod_lo`. For example, 80h × FFh gives 0080h with `ovf`=1.
- R6: A start is accepted at a rising edge where `start`=1 and `busy`=0. `busy` is 1 from that edge until the (N+1)th rising edge after it. `done` is 1 for exactly one cycle, which begins at the (N+1)th rising edge after the accepting edge.
- R7: A `start` pulse while `busy`=1 is ignored. The result in progress, its timing and its operands are unchanged, and no extra `done` follows.
- R8: `prod_hi`, `prod_lo` and `ovf` change only at the edge that raises `done`. They hold while the inputs change.
- R9: For the same operands, signed and unsigned modes give the same `prod_lo`.
- R10: The most negative operand value (bit N-1 set, all other bits 0) is handled as a full magnitude. For example, 80h × 80h signed gives 4000h, and 80h × 01h signed gives FF80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (ignored while busy) |
| sgn_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opa | input | N | Multiplicand |
| opb | input | N | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when a new product is published |
| prod_hi | output | N | Upper half of the product |
| prod_lo | output | N | Lower half of the product |
| ovf | output | 1 | Product does not fit in the low half (carry/overflow) |

## Verification
Counting from the edge that accepts `start`, `busy` must be seen high after that edge and after each of the next N edges. `done`, the product and `ovf` must first appear after edge N+1, and `done` must be low again after edge N+2. The bench drives inputs on falling edges and counts rising edges one by one from acceptance. It samples each result at the falling edge that follows the edge where it becomes due, and checks both the cycle before and the cycle after. Operands are changed right after acceptance, and a second start is pulsed mid-run, so that any late capture shows up in the published value.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sgn,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_res
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg   = sgn & a_in[W-1];
        b_neg   = sgn & b_in[W-1];
        // the most negative value maps to 2^(W-1), still representable unsigned
        mag_a   = a_neg ? (~a_in + 1'b1) : a_in;
        mag_b   = b_neg ? (~b_in + 1'b1) : b_in;
        neg_res = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_shift_core.sv
module mul_shift_core #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplr_in,
    output logic [2*W-1:0] acc,
    output logic           last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  mcand;
    logic [W-1:0]  mplr;
    logic [CW-1:0] cnt;
    logic [W:0]    sum;

    always_comb begin
        // bit 0 of the multiplier acts as the shifted-out carry selecting the add
        sum  = {1'b0, acc[2*W-1:W]} + (mplr[0] ? {1'b0, mcand} : '0);
        last = (cnt == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            mcand <= '0;
            mplr  <= '0;
            cnt   <= '0;
        end else if (load) begin
            acc   <= '0;
            mcand <= mcand_in;
            mplr  <= mplr_in;
            cnt   <= CW'(W);
        end else if (step) begin
            mplr <= mplr >> 1;
            // rotate right through carry: adder carry-out enters at the msb
            acc  <= {sum[W], sum[W-1:0], acc[W-1:1]};
            cnt  <= cnt - 1'b1;
        end
    end

    // R6: one iteration per cycle, counter steps down by one
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt > CW'(1)) |=> (cnt == $past(cnt) - 1'b1));

    // R2: without an add the carry into the msb is zero
    a_r2_no_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mplr[0]) |=> !acc[2*W-1]);
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] mag_prod,
    input  logic           neg,
    input  logic           sgn,
    output logic [2*W-1:0] result,
    output logic           ovf
);
    logic [W-1:0] hi;
    logic [W-1:0] lo;

    always_comb begin
        result = neg ? (~mag_prod + 1'b1) : mag_prod;
        hi     = result[2*W-1:W];
        lo     = result[W-1:0];
        if (sgn)
            ovf = (hi != {W{lo[W-1]}});
        else
            ovf = (hi != '0);
    end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mulseq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn_mode,
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] prod_hi,
    output logic [N-1:0] prod_lo,
    output logic         ovf
);
    localparam int PW = 2 * N;

    ctl_state_t    state;
    ctl_state_t    state_nx;
    logic          load;
    logic          step;
    logic          last;
    logic [N-1:0]  mag_a;
    logic [N-1:0]  mag_b;
    logic          neg_in;
    logic          neg_q;
    logic          sgn_q;
    logic [PW-1:0] acc;
    logic [PW-1:0] fixed;
    logic          ovf_nx;

    mul_operand_prep #(.W(N)) u_prep (
        .a_in    (opa),
        .b_in    (opb),
        .sgn     (sgn_mode),
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .neg_res (neg_in)
    );

    mul_shift_core #(.W(N)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mcand_in (mag_a),
        .mplr_in  (mag_b),
        .acc      (acc),
        .last     (last)
    );

    mul_result_fix #(.W(N)) u_fix (
        .mag_prod (acc),
        .neg      (neg_q),
        .sgn      (sgn_q),
        .result   (fixed),
        .ovf      (ovf_nx)
    );

    always_comb begin
        load     = (state == ST_IDLE) && start;
        step     = (state == ST_ITER);
        busy     = (state != ST_IDLE);
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_ITER;
            ST_ITER: if (last)  state_nx = ST_FIX;
            ST_FIX:             state_nx = ST_IDLE;
            default:            state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and captured mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            prod_hi <= '0;
            prod_lo <= '0;
            ovf     <= 1'b0;
            neg_q   <= 1'b0;
            sgn_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                neg_q <= neg_in;
                sgn_q <= sgn_mode;
            end
            if (state == ST_FIX) begin
                done    <= 1'b1;
                prod_hi <= fixed[PW-1:N];
                prod_lo <= fixed[N-1:0];
                ovf     <= ovf_nx;
            end
        end
    end

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done appears only once the machine is idle again
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: results hold except at the publishing edge
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({prod_hi, prod_lo, ovf}));

    // R7: a start during a run does not restart or end it
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state == ST_ITER && !last) |=> (state == ST_ITER));
endmodule

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn_mode = 1'b0;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic         busy;
    logic         done;
    logic [N-1:0] prod_hi;
    logic [N-1:0] prod_lo;
    logic         ovf;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    shift_add_mul #(.N(N)) i_shift_add_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] model_prod(input logic [N-1:0] a, input logic [N-1:0] b, input logic s);
        logic signed [2*N-1:0] sp;
        if (s) begin
            sp = $signed({{N{a[N-1]}}, a}) * $signed({{N{b[N-1]}}, b});
            return sp;
        end
        return {{N{1'b0}}, a} * {{N{1'b0}}, b};
    endfunction

    function automatic logic model_ovf(input logic [2*N-1:0] p, input logic s);
        if (s) return p[2*N-1:N] != {N{p[N-1]}};
        return p[2*N-1:N] != '0;
    endfunction

    // Runs one multiplication; if inject > 0 a second start pulse is sent
    // after that many edges. Returns the published product.
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b, input logic s,
                           input string req, input int inject, output logic [2*N-1:0] got);
        logic [2*N-1:0] exp_p;
        bit tim_ok;
        exp_p = model_prod(a, b, s);
        @(negedge clk);
        opa = a; opb = b; sgn_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = a ^ 8'h5A; sgn_mode = ~s;
        tim_ok = (busy === 1'b1) && (done === 1'b0);
        for (int k = 1; k <= N + 1; k++) begin
            if (k == inject) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (k <= N) tim_ok &= (busy === 1'b1) && (done === 1'b0);
        end
        // R6: done due after edge N+1
        check(tim_ok && done === 1'b1 && busy === 1'b0, "R6 timing", {busy, done}, 2'b01);
        got = {prod_hi, prod_lo};
        check(got === exp_p, req, got, exp_p);
        check(ovf === model_ovf(exp_p, s), s ? "R5 signed flag" : "R4 unsigned flag", ovf, model_ovf(exp_p, s));
        @(negedge clk);
        check(done === 1'b0, "R6 done one cycle", done, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check({prod_hi, prod_lo, ovf, done, busy} === '0, "R1 reset state",
              {prod_hi, prod_lo, ovf, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unsigned;
        logic [2*N-1:0] g;
        run_mul(8'h06, 8'h0A, 1'b0, "R2 unsigned 6x10", 0, g);
        run_mul(8'hFF, 8'hFF, 1'b0, "R2 unsigned FFxFF", 0, g);
        run_mul(8'h00, 8'hC3, 1'b0, "R2 unsigned zero", 0, g);
        run_mul(8'h30, 8'h04, 1'b0, "R4 unsigned fits", 0, g);
        run_mul(8'h80, 8'hFF, 1'b0, "R2 unsigned 80xFF", 0, g);
    endtask

    task automatic t_signed;
        logic [2*N-1:0] g;
        run_mul(8'h80, 8'hFF, 1'b1, "R5 signed 80xFF", 0, g);
        run_mul(8'hFF, 8'hFF, 1'b1, "R3 signed -1x-1", 0, g);
        run_mul(8'hF1, 8'h07, 1'b1, "R3 signed -15x7", 0, g);
        run_mul(8'h30, 8'h04, 1'b1, "R5 signed 30x04", 0, g);
        run_mul(8'h7F, 8'h7F, 1'b1, "R3 signed max", 0, g);
        run_mul(8'hFB, 8'h00, 1'b1, "R3 signed zero", 0, g);
    endtask

    task automatic t_most_neg;
        logic [2*N-1:0] g;
        run_mul(8'h80, 8'h80, 1'b1, "R10 80x80", 0, g);
        check(g === 16'h4000, "R10 80x80 value", g, 16'h4000);
        run_mul(8'h80, 8'h01, 1'b1, "R10 80x01", 0, g);
        check(g === 16'hFF80, "R10 80x01 value", g, 16'hFF80);
    endtask

    task automatic t_low_same;
        logic [2*N-1:0] gu;
        logic [2*N-1:0] gs;
        run_mul(8'hB7, 8'hE5, 1'b0, "R2 pair unsigned", 0, gu);
        run_mul(8'hB7, 8'hE5, 1'b1, "R3 pair signed", 0, gs);
        check(gu[N-1:0] === gs[N-1:0], "R9 low half equal", gs[N-1:0], gu[N-1:0]);
    endtask

    task automatic t_busy_ignore;
        logic [2*N-1:0] g;
        bit extra;
        run_mul(8'h13, 8'h2D, 1'b0, "R7 start ignored result", 3, g);
        extra = 1'b0;
        for (int k = 0; k < N + 4; k++) begin
            @(negedge clk);
            if (done !== 1'b0 || busy !== 1'b0) extra = 1'b1;
        end
        check(!extra, "R7 no second run", extra, 0);
    endtask

    task automatic t_hold;
        logic [2*N-1:0] g;
        logic [2*N-1:0] held;
        bit moved;
        run_mul(8'h9C, 8'h35, 1'b1, "R3 hold setup", 0, g);
        held = {prod_hi, prod_lo};
        moved = 1'b0;
        for (int k = 0; k < 6; k++) begin
            opa = 8'(k * 37); opb = 8'(k + 200); sgn_mode = k[0];
            @(negedge clk);
            if ({prod_hi, prod_lo} !== held || done !== 1'b0) moved = 1'b1;
        end
        check(!moved, "R8 outputs hold", {prod_hi, prod_lo}, held);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_unsigned();
                t_signed();
                t_most_neg();
                t_low_same();
                t_busy_ignore();
                t_hold();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule